// File: doc/BRIEF.md
# Bit-Sliced Integer Arithmetic-Logic Unit

A purely combinational arithmetic-logic unit for the execute stage of a simple integer datapath. Its default operands are 32 bits wide, and a 4-bit function code selects what it computes. The unit builds every operation from one ripple chain of identical bit slices. Each slice can invert its A bit and its B bit before the AND, OR and full-adder cells. The low two bits of the function code then choose which cell output drives the result.

Bit 3 of the function code inverts operand A. Bit 2 inverts operand B and also sets the carry into the lowest slice, which turns addition into two's complement subtraction. With this scheme one adder gives add, subtract and signed set-less-than. The same inversion lines give NOR as the AND of the two inverted operands. Three outputs go back to the datapath: a zero flag for branch decisions and a signed overflow flag for the arithmetic operations, alongside the result itself.

Top module: `alu_core`

## Requirements
- R1: Function code 4'b0000 drives the result with the bitwise AND of A and B.
- R2: Function code 4'b0001 drives the result with the bitwise OR of A and B.
- R3: Function code 4'b0010 drives the result with A plus B, modulo 2^WIDTH.
- R4: Function code 4'b0110 drives the result with A minus B, modulo 2^WIDTH.
- R5: Function code 4'b0111 sets result bit 0 to 1 when A is less than B as signed two's complement numbers, and to 0 otherwise. All other result bits are 0. The comparison stays correct when the subtraction overflows.
- R6: Function code 4'b1100 drives the result with the bitwise NOR of A and B.
- R7: The zero flag is 1 exactly when every result bit is 0.
- R8: For function codes 4'b0010 and 4'b0110, the overflow flag is 1 exactly when the true signed sum or difference falls outside the signed WIDTH-bit range.
- R9: For every function code other than 4'b0010 and 4'b0110, the overflow flag is 0.
- R10: Any function code not listed in R1 to R6 gives a result of all zeros, so the zero flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| func | input | 4 | Function code: bit 3 inverts A, bit 2 negates B, bits 1:0 pick the cell output |
| res | output | WIDTH | Result |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds two copies of the unit side by side: the default 32-bit width and an 8-bit width. Every vector drives both. At 8 bits, random operands land often on the signed limits, on carries out of the top slice and on equal operands. This exercises overflow in both directions, set-less-than across an overflowing subtraction, and zero results from subtraction. Directed 32-bit vectors then confirm the same corners at full width, and every one of the sixteen function codes is applied to both widths.

// File: rtl/alu_core.sv
module alu_core #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       func,
  output logic [WIDTH-1:0] res,
  output logic             zero,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic             a_inv;
  logic             b_neg;
  logic [WIDTH:0]   carry;
  logic [MSB:0]     a_x, b_x, s_and, s_or, s_sum;
  logic             ovf_raw;
  logic             less;
  logic             is_arith;

  assign a_inv    = func[3];
  assign b_neg    = func[2];
  assign carry[0] = b_neg;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign a_x[i]     = opa[i] ^ a_inv;
    assign b_x[i]     = opb[i] ^ b_neg;
    assign s_and[i]   = a_x[i] & b_x[i];
    assign s_or[i]    = a_x[i] | b_x[i];
    assign s_sum[i]   = a_x[i] ^ b_x[i] ^ carry[i];
    assign carry[i+1] = (a_x[i] & b_x[i]) | (carry[i] & (a_x[i] ^ b_x[i]));
  end

  assign ovf_raw  = carry[WIDTH] ^ carry[MSB];
  assign less     = s_sum[MSB] ^ ovf_raw;
  assign is_arith = (func == 4'b0010) || (func == 4'b0110);

  always_comb begin
    case (func)
      4'b0000, 4'b1100: res = s_and;
      4'b0001:          res = s_or;
      4'b0010, 4'b0110: res = s_sum;
      4'b0111:          res = {{MSB{1'b0}}, less};
      default:          res = '0;
    endcase
  end

  assign zero = ~|res;
  assign ovf  = is_arith & ovf_raw;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [3:0]       func,
  input logic [WIDTH-1:0] res,
  input logic             zero,
  input logic             ovf
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (func == 4'b0000)
      p_and_subset_r1: assert ((res & ~opa) == '0 && (res & ~opb) == '0);
    if (func == 4'b0001)
      p_or_covers_r2: assert ((res & opa) == opa && (res & opb) == opb);
    if (func == 4'b0010 && ovf)
      p_add_ovf_signs_r3: assert (opa[MSB] == opb[MSB] && res[MSB] != opa[MSB]);
    if (func == 4'b0110 && ovf)
      p_sub_ovf_signs_r4: assert (opa[MSB] != opb[MSB] && res[MSB] != opa[MSB]);
    if (func == 4'b0111)
      p_slt_shape_r5: assert (res[MSB:1] == '0);
    if (func == 4'b1100)
      p_nor_disjoint_r6: assert ((res & (opa | opb)) == '0);
    if (zero)
      p_zero_means_empty_r7: assert (res == '0);
    if (func != 4'b0010 && func != 4'b0110)
      p_no_overflow_r9: assert (!ovf);
    if (!(func inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100}))
      p_undef_clear_r10: assert (res == '0 && zero);
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .opa (opa),
  .opb (opb),
  .func(func),
  .res (res),
  .zero(zero),
  .ovf (ovf)
);

// File: tb/alu_core_bench.sv
module alu_core_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] a32, b32, y32;
  logic [7:0]  a8, b8, y8;
  logic [3:0]  fn;
  logic        z32, v32, z8, v8;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  alu_core #(.WIDTH(32)) u_alu_core (
    .opa(a32), .opb(b32), .func(fn), .res(y32), .zero(z32), .ovf(v32));
  alu_core #(.WIDTH(8)) u_alu_core_w8 (
    .opa(a8), .opb(b8), .func(fn), .res(y8), .zero(z8), .ovf(v8));

  function automatic longint sx(longint unsigned v, int w);
    return v[w-1] ? longint'(v) - (longint'(1) << w) : longint'(v);
  endfunction

  function automatic longint unsigned exp_res(longint unsigned a, longint unsigned b,
                                              logic [3:0] f, int w);
    longint unsigned m = (longint'(1) << w) - 1;
    case (f)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return (a + b) & m;
      4'b0110: return (a - b) & m;
      4'b0111: return (sx(a, w) < sx(b, w)) ? 1 : 0;
      4'b1100: return ~(a | b) & m;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_ovf(longint unsigned a, longint unsigned b,
                                 logic [3:0] f, int w);
    longint t;
    longint lim = longint'(1) << (w - 1);
    if (f == 4'b0010) t = sx(a, w) + sx(b, w);
    else if (f == 4'b0110) t = sx(a, w) - sx(b, w);
    else return 1'b0;
    return (t >= lim) || (t < -lim);
  endfunction

  function automatic string tag_of(logic [3:0] f);
    case (f)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, longint unsigned got, longint unsigned exp, string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (a=%0h b=%0h f=%b)",
               req, what, got, exp, a32, b32, fn);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] b, logic [31:0] a_n, logic [3:0] f);
    longint unsigned e32, e8;
    @(posedge clk);
    a32 = a; b32 = b; a8 = a_n[7:0]; b8 = b[7:0]; fn = f;
    @(negedge clk);
    e32 = exp_res(a, b, f, 32);
    e8  = exp_res(a_n[7:0], b[7:0], f, 8);
    check(tag_of(f), y32, e32, "res32");
    check(tag_of(f), y8, e8, "res8");
    check("R7", z32, (e32 == 0), "zero32");
    check("R7", z8, (e8 == 0), "zero8");
    if (f == 4'b0010 || f == 4'b0110) begin
      check("R8", v32, exp_ovf(a, b, f, 32), "ovf32");
      check("R8", v8, exp_ovf(a_n[7:0], b[7:0], f, 8), "ovf8");
    end else begin
      check("R9", v32, 0, "ovf32");
      check("R9", v8, 0, "ovf8");
    end
  endtask

  function automatic logic [31:0] pick_val(int unsigned r, int unsigned k);
    case (k % 6)
      0: return 32'h7fff_ffff;
      1: return 32'h8000_0000;
      2: return 32'hffff_ffff;
      3: return 32'h0000_0000;
      4: return {24'h0, 8'h80 ^ r[7:0]};
      default: return r;
    endcase
  endfunction

  function automatic logic [3:0] pick_op(int unsigned r);
    case (r % 7)
      0: return 4'b0000;
      1: return 4'b0001;
      2: return 4'b0010;
      3: return 4'b0110;
      4: return 4'b0111;
      5: return 4'b1100;
      default: return r[7:4];
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20240611);
    a32 = '0; b32 = '0; a8 = '0; b8 = '0; fn = 4'b0000;
    @(negedge clk);
    check("R1", y32, 0, "initial and");
    check("R7", z32, 1, "initial zero");

    // R3 R8: positive overflow at both widths
    apply(32'h7fff_ffff, 32'h0000_0001, 32'h0000_007f, 4'b0010);
    // R3: carry out without signed overflow
    apply(32'hffff_ffff, 32'h0000_0001, 32'h0000_00ff, 4'b0010);
    // R4 R8: negative overflow
    apply(32'h8000_0000, 32'h0000_0001, 32'h0000_0080, 4'b0110);
    // R4 R7: equal operands give zero
    apply(32'h1234_5678, 32'h1234_5678, 32'h0000_0078, 4'b0110);
    // R5: overflowing compare, min < max and max not < min
    apply(32'h8000_0000, 32'h7fff_ffff, 32'h0000_0080, 4'b0111);
    apply(32'h7fff_ffff, 32'h8000_0000, 32'h0000_007f, 4'b0111);
    apply(32'hffff_ffff, 32'h0000_0000, 32'h0000_00ff, 4'b0111);
    apply(32'h0000_0005, 32'h0000_0005, 32'h0000_0005, 4'b0111);
    // R6: NOR of zeros is all ones
    apply(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 4'b1100);
    // every code, R9 and R10 included
    for (int f = 0; f < 16; f++)
      apply(32'hdead_beef, 32'h0f0f_f0f0, 32'h0000_00ef, f[3:0]);

    for (int n = 0; n < 4000; n++) begin
      int unsigned ra, rb, rc, rk;
      logic [31:0] va, vb;
      ra = $urandom; rb = $urandom; rc = $urandom; rk = $urandom;
      va = pick_val(ra, rk);
      vb = pick_val(rb, rk >> 4);
      apply(va, vb, va, pick_op(rc));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule